// File: doc/BRIEF.md
# Two-Stage Pad Input Capture Cell

This block models the input path of a group of programmable I/O pads. Each pad value first passes an optional polarity inversion. A fast-capture latch then catches it. That latch is opened by a dedicated edge clock and is independent of the system clock. A second storage stage follows it on the system clock. Its static configuration picks between a level-sensitive latch and an edge-triggered flip-flop. The fabric receives two signals per pad: the direct, polarity-adjusted value and the value held in the second stage.

Because the two stages run on separate clocks, the cell can split a multiplexed address/data input without a separate demultiplexer. The edge clock closes the capture latch on the address phase. The system clock then moves that held value into the second stage while the pad already carries data, and the direct output shows that data. The second stage has a clock enable, a local set/reset and a global set/reset. A configuration bit chooses whether set/reset means set or clear. Another field chooses how the local set/reset ranks against the clock enable. A third bit lets the global set/reset reach the cell or masks it.

Top module: `incap_cell`

## Requirements
- R1: The configuration inputs are copied into the cell only on system clock edges while `rst` is high. Changing them afterwards has no effect on any output.
- R2: `direct_o` equals `pad_i` when the sampled invert bit is 0 and its bitwise complement when it is 1. The same polarity applies to the value that is stored.
- R3: The capture latch passes the polarity-adjusted pad value while `eclk` is high and holds it while `eclk` is low. The second stage takes its data from the capture latch, so a pad change after `eclk` falls does not reach `stored_o`.
- R4: In flip-flop mode (`cfg_latch_mode_i`=0), `stored_o` loads the capture value at a rising `clk` edge when `ce_i` is 1 and holds it when `ce_i` is 0.
- R5: In latch mode (`cfg_latch_mode_i`=1), `stored_o` follows the capture value while `clk` is high and `ce_i` is 1, and holds while `clk` is low.
- R6: Priority code 0 (enable first): `lsr_i` loads the init value only at a clock edge or open phase where `ce_i` is also 1. Without `ce_i` it has no effect.
- R7: Priority codes 1 and 3 (set/reset first): `lsr_i` loads the init value at the clock regardless of `ce_i`. It does not act before the clock.
- R8: Priority code 2 (asynchronous): `lsr_i` forces the init value at once, without a clock edge, in either storage mode.
- R9: The init value is all ones when `cfg_init_set_i` is 1 and all zeros when it is 0.
- R10: With `cfg_gsr_en_i`=1, `gsr_i` forces the init value at once. With `cfg_gsr_en_i`=0, `gsr_i` is ignored.
- R11: While `rst` is high, the second stage is loaded with the init value on the system clock.
- R12: After an address phase has been captured, `stored_o` presents the address while `direct_o` presents the data phase currently on the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the second stage and the configuration register |
| rst | input | 1 | Synchronous active-high reset; samples configuration and loads the init value |
| eclk | input | 1 | Edge clock; capture latch is transparent while high |
| pad_i | input | W | Pad input values |
| ce_i | input | 1 | Clock enable of the second stage |
| lsr_i | input | 1 | Local set/reset |
| gsr_i | input | 1 | Global set/reset |
| cfg_invert_i | input | 1 | 1 inverts the pad polarity |
| cfg_latch_mode_i | input | 1 | 1 makes the second stage a latch, 0 a flip-flop |
| cfg_init_set_i | input | 1 | 1 makes set/reset set, 0 makes it clear |
| cfg_prio_i | input | 2 | 0 enable first, 1 and 3 set/reset first, 2 asynchronous set/reset |
| cfg_gsr_en_i | input | 1 | 1 lets the global set/reset reach this cell |
| direct_o | output | W | Direct polarity-adjusted pad value |
| stored_o | output | W | Value held in the second stage |

## Verification
The bench changes the pad after the edge clock has fallen and before the system edge. A cell that fed the second stage straight from the pad would then store the data phase instead of the address. Set/reset is driven with the clock enable low and between clock edges, under each priority code. A wrong priority decode then shows as an early, missing or unwanted load of the init value. In latch mode the bench samples during both clock phases, so a second stage built as a flip-flop, or left open while the clock is low, gives a visible mismatch. Configuration inputs are altered after reset to expose a cell that reads them continuously instead of holding the sampled copy.

// File: rtl/incap_pkg.sv
`timescale 1ns/1ps
package incap_pkg;

  typedef enum logic [1:0] {
    PRIO_CE_FIRST  = 2'd0,
    PRIO_LSR_FIRST = 2'd1,
    PRIO_ASYNC     = 2'd2,
    PRIO_RSVD      = 2'd3
  } prio_e;

  typedef struct packed {
    logic  invert;
    logic  latch_mode;
    logic  init_set;
    prio_e prio;
    logic  gsr_en;
  } cfg_t;

endpackage

// File: rtl/incap_cfg_reg.sv
`timescale 1ns/1ps
module incap_cfg_reg
  import incap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);

  // configuration is static: copied only while reset is held
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/incap_capture_latch.sv
`timescale 1ns/1ps
module incap_capture_latch #(
  parameter int W = 4
) (
  input  logic         eclk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_latch begin
      if (eclk) q[i] <= d[i];
    end
  end

endmodule

// File: rtl/incap_stage2.sv
`timescale 1ns/1ps
module incap_stage2
  import incap_pkg::*;
#(
  parameter int W              = 4,
  parameter bit HAS_LATCH_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  cfg_t         cfg,
  input  logic [W-1:0] d,
  input  logic         ce,
  input  logic         lsr,
  input  logic         gsr,
  output logic [W-1:0] q
);

  logic [W-1:0] initv;
  logic         arst;
  logic         lsr_wins;
  logic [W-1:0] ff_q;
  logic [W-1:0] lat_q;

  assign initv = {W{cfg.init_set}};
  // asynchronous force: local set/reset in async mode, or enabled global
  assign arst  = ((cfg.prio == PRIO_ASYNC) & lsr) | (cfg.gsr_en & gsr);

  // synchronous set/reset decision by priority mode
  always_comb begin
    case (cfg.prio)
      PRIO_CE_FIRST: lsr_wins = lsr & ce;
      PRIO_ASYNC:    lsr_wins = 1'b0;
      default:       lsr_wins = lsr;
    endcase
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)          ff_q <= initv;
    else if (rst)      ff_q <= initv;
    else if (lsr_wins) ff_q <= initv;
    else if (ce)       ff_q <= d;
  end

  if (HAS_LATCH_MODE) begin : g_latch
    always_latch begin
      if (arst) lat_q <= initv;
      else if (clk) begin
        if (rst)           lat_q <= initv;
        else if (lsr_wins) lat_q <= initv;
        else if (ce)       lat_q <= d;
      end
    end
    assign q = cfg.latch_mode ? lat_q : ff_q;
  end else begin : g_ff_only
    assign lat_q = ff_q;
    assign q     = ff_q;
  end

  a_r8_async_force: assert property (@(posedge clk) disable iff (rst)
    (cfg.prio == PRIO_ASYNC && lsr) |-> (q == initv));

  a_r10_gsr_force: assert property (@(posedge clk) disable iff (rst)
    (cfg.gsr_en && gsr) |-> (q == initv));

  a_r7_lsr_over_ce: assert property (@(posedge clk) disable iff (rst)
    (!cfg.latch_mode && (cfg.prio == PRIO_LSR_FIRST || cfg.prio == PRIO_RSVD) && lsr)
    |=> (ff_q == initv));

  a_r4_ce_hold: assert property (@(posedge clk) disable iff (rst)
    (!cfg.latch_mode && !ce && !lsr)
    |=> ($stable(ff_q) || ff_q == initv));

  a_r6_lsr_needs_ce: assert property (@(posedge clk) disable iff (rst)
    (!cfg.latch_mode && cfg.prio == PRIO_CE_FIRST && !ce)
    |=> ($stable(ff_q) || ff_q == initv));

endmodule

// File: rtl/incap_cell.sv
`timescale 1ns/1ps
module incap_cell
  import incap_pkg::*;
#(
  parameter int W              = 4,
  parameter bit HAS_LATCH_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         eclk,
  input  logic [W-1:0] pad_i,
  input  logic         ce_i,
  input  logic         lsr_i,
  input  logic         gsr_i,
  input  logic         cfg_invert_i,
  input  logic         cfg_latch_mode_i,
  input  logic         cfg_init_set_i,
  input  logic [1:0]   cfg_prio_i,
  input  logic         cfg_gsr_en_i,
  output logic [W-1:0] direct_o,
  output logic [W-1:0] stored_o
);

  cfg_t         cfg_in;
  cfg_t         cfg_q;
  logic [W-1:0] pad_pol;
  logic [W-1:0] cap_q;

  assign cfg_in.invert     = cfg_invert_i;
  assign cfg_in.latch_mode = cfg_latch_mode_i;
  assign cfg_in.init_set   = cfg_init_set_i;
  assign cfg_in.prio       = prio_e'(cfg_prio_i);
  assign cfg_in.gsr_en     = cfg_gsr_en_i;

  incap_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  assign pad_pol  = pad_i ^ {W{cfg_q.invert}};
  assign direct_o = pad_pol;

  incap_capture_latch #(.W(W)) u_cap (
    .eclk (eclk),
    .d    (pad_pol),
    .q    (cap_q)
  );

  incap_stage2 #(.W(W), .HAS_LATCH_MODE(HAS_LATCH_MODE)) u_st2 (
    .clk (clk),
    .rst (rst),
    .cfg (cfg_q),
    .d   (cap_q),
    .ce  (ce_i),
    .lsr (lsr_i),
    .gsr (gsr_i),
    .q   (stored_o)
  );

  a_r3_capture_open: assert property (@(posedge clk) disable iff (rst)
    eclk |-> (cap_q == direct_o));

endmodule

// File: tb/tb_incap_cell.sv
`timescale 1ns/1ps
module tb_incap_cell;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         eclk = 1'b0;
  logic [W-1:0] pad_i = '0;
  logic         ce_i = 1'b0;
  logic         lsr_i = 1'b0;
  logic         gsr_i = 1'b0;
  logic         cfg_invert_i = 1'b0;
  logic         cfg_latch_mode_i = 1'b0;
  logic         cfg_init_set_i = 1'b0;
  logic [1:0]   cfg_prio_i = 2'd1;
  logic         cfg_gsr_en_i = 1'b1;
  logic [W-1:0] direct_o;
  logic [W-1:0] stored_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  incap_cell #(.W(W)) dut (
    .clk              (clk),
    .rst              (rst),
    .eclk             (eclk),
    .pad_i            (pad_i),
    .ce_i             (ce_i),
    .lsr_i            (lsr_i),
    .gsr_i            (gsr_i),
    .cfg_invert_i     (cfg_invert_i),
    .cfg_latch_mode_i (cfg_latch_mode_i),
    .cfg_init_set_i   (cfg_init_set_i),
    .cfg_prio_i       (cfg_prio_i),
    .cfg_gsr_en_i     (cfg_gsr_en_i),
    .direct_o         (direct_o),
    .stored_o         (stored_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic inv, input logic lat, input logic set,
                          input logic [1:0] prio, input logic gen);
    @(negedge clk);
    cfg_invert_i = inv; cfg_latch_mode_i = lat; cfg_init_set_i = set;
    cfg_prio_i = prio; cfg_gsr_en_i = gen;
    ce_i = 0; lsr_i = 0; gsr_i = 0; rst = 1;
    eclk = 1; #0.5; eclk = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic capture(input logic [W-1:0] v);
    @(negedge clk);
    pad_i = v; eclk = 1; #0.5; eclk = 0; #0.2;
  endtask

  task automatic clk_edge(input logic c, input logic l);
    ce_i = c; lsr_i = l;
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [W-1:0] v);
    capture(v);
    clk_edge(1'b1, 1'b0);
    ce_i = 0;
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0, 2'd1, 1);
    chk("R11 reset clears", stored_o, 4'h0);
    do_reset(0, 0, 1, 2'd1, 1);
    chk("R9 R11 reset sets", stored_o, 4'hF);
  endtask

  task automatic t_invert();
    do_reset(1, 0, 0, 2'd1, 1);
    @(negedge clk); pad_i = 4'h3; #0.5;
    chk("R2 direct inverted", direct_o, 4'hC);
    cfg_invert_i = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 cfg change ignored", direct_o, 4'hC);
    load(4'h3);
    chk("R2 stored inverted", stored_o, 4'hC);
    cfg_invert_i = 1;
  endtask

  task automatic t_ff_path();
    do_reset(0, 0, 0, 2'd1, 1);
    capture(4'hA);
    pad_i = 4'h5;
    clk_edge(1, 0);
    chk("R3 held capture stored", stored_o, 4'hA);
    chk("R12 direct shows data", direct_o, 4'h5);
    capture(4'h6);
    clk_edge(0, 0);
    chk("R4 ce low holds", stored_o, 4'hA);
    clk_edge(1, 0);
    chk("R4 ce high loads", stored_o, 4'h6);
    @(negedge clk);
    pad_i = 4'h9; eclk = 1; #0.3; pad_i = 4'hB; #0.3; eclk = 0; #0.1; pad_i = 4'hC;
    clk_edge(1, 0);
    chk("R3 last open value", stored_o, 4'hB);
    ce_i = 0;
  endtask

  task automatic t_latch();
    do_reset(0, 1, 0, 2'd1, 1);
    capture(4'h7);
    ce_i = 1;
    #0.3;
    chk("R5 closed while clk low", stored_o, 4'h0);
    @(posedge clk); #0.5;
    chk("R5 opens on clk high", stored_o, 4'h7);
    pad_i = 4'h9; eclk = 1; #0.3;
    chk("R5 transparent when high", stored_o, 4'h9);
    eclk = 0;
    capture(4'h2);
    chk("R5 holds while clk low", stored_o, 4'h9);
    ce_i = 0;
  endtask

  task automatic t_prio0();
    do_reset(0, 0, 1, 2'd0, 1);
    load(4'h5);
    chk("R6 load", stored_o, 4'h5);
    clk_edge(0, 1);
    chk("R6 lsr without ce ignored", stored_o, 4'h5);
    clk_edge(1, 1);
    chk("R6 lsr with ce sets", stored_o, 4'hF);
    ce_i = 0; lsr_i = 0;
  endtask

  task automatic t_prio1();
    do_reset(0, 0, 0, 2'd1, 1);
    load(4'h5);
    @(negedge clk); lsr_i = 1; #0.5;
    chk("R7 lsr waits for clock", stored_o, 4'h5);
    clk_edge(0, 1);
    chk("R7 lsr beats ce", stored_o, 4'h0);
    lsr_i = 0;
    do_reset(0, 0, 0, 2'd3, 1);
    load(4'h5);
    clk_edge(0, 1);
    chk("R7 code 3 like code 1", stored_o, 4'h0);
    lsr_i = 0;
  endtask

  task automatic t_async();
    do_reset(0, 0, 1, 2'd2, 1);
    load(4'h5);
    @(negedge clk); lsr_i = 1; #0.5;
    chk("R8 async set ff mode", stored_o, 4'hF);
    lsr_i = 0;
    do_reset(0, 1, 0, 2'd2, 1);
    load(4'h5);
    chk("R8 latch load", stored_o, 4'h5);
    @(negedge clk); lsr_i = 1; #0.5;
    chk("R8 async clear latch mode", stored_o, 4'h0);
    lsr_i = 0;
  endtask

  task automatic t_gsr();
    do_reset(0, 0, 0, 2'd1, 1);
    load(4'h5);
    @(negedge clk); gsr_i = 1; #0.5;
    chk("R10 gsr forces", stored_o, 4'h0);
    gsr_i = 0;
    do_reset(0, 0, 1, 2'd1, 0);
    load(4'h5);
    gsr_i = 1;
    clk_edge(0, 0);
    chk("R10 gsr masked", stored_o, 4'h5);
    gsr_i = 0;
  endtask

  initial begin
    t_reset();
    t_invert();
    t_ff_path();
    t_latch();
    t_prio0();
    t_prio1();
    t_async();
    t_gsr();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule